// File: doc/BRIEF.md
# Character Blink Timing Generator

This block produces the on/off phase used to blink characters and the cursor of a text overlay. It counts rising edges of the vertical sync signal in a field counter that wraps. It then compares the counter with a threshold set by a programmed period and duty. The result is a single blink phase. That phase switches off a character only when the character's own blink attribute is set. It switches off the cursor only when cursor blinking is enabled.

The period select and the duty code come from a control register outside this block. The block copies both into shadow registers on each vertical sync edge. A change made in the middle of a field therefore takes effect at the next field boundary, and the counter keeps running through the change. The cell attribute and the cursor enable act on the outputs in the same cycle, through combinational logic only. This lets a character fetch pipeline present a new cell on every clock.

Top module: `blink_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the field counter returns to 0 and the shadow duty code returns to 00 (blinking off). The shadow period bit returns to 0 (64 fields). Both visibility outputs are then 1, whatever the inputs.
- R2: The field counter is 6 bits wide. It advances by exactly one for each 0-to-1 transition of `vsync` seen at the clock, however long `vsync` stays high. It wraps from 63 to 0.
- R3: When the shadow `half_period` bit is 0, the blink period is 64 fields and the phase position is the full counter value. When the bit is 1, the period is 32 fields and the position is the counter's lower 5 bits.
- R4: The duty codes are 00 = blinking off (always visible), 01 = visible while position < P/4, 10 = visible while position < P/2, and 11 = visible while position < 3P/4, where P is the active period.
- R5: When `cell_blink` is 0, `char_visible` is 1. When it is 1, `char_visible` follows the blink phase. This holds in the same cycle.
- R6: When `cursor_blink_en` is 0, `cursor_visible` is 1. When it is 1, `cursor_visible` follows the blink phase. This holds in the same cycle.
- R7: A change of `duty` or `half_period` has no effect on the outputs until the next `vsync` rising edge. The block captures the new value at that edge, and the counter is not reset by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low clear |
| vsync | input | 1 | Vertical sync, synchronous to `clk`, active high |
| half_period | input | 1 | 0: 64-field period, 1: 32-field period |
| duty | input | 2 | 00 off, 01 25 %, 10 50 %, 11 75 % visible |
| cell_blink | input | 1 | Blink attribute of the current cell |
| cursor_blink_en | input | 1 | Enables cursor blinking |
| char_visible | output | 1 | Current character may be drawn |
| cursor_visible | output | 1 | Cursor may be drawn |

## Verification
The bench sweeps every combination of period and duty through a full 64-field revolution. At each field it tries all four combinations of the cell attribute and the cursor enable. This separates the correct threshold from a neighbouring one and the 5-bit position from the 6-bit one. It also separates a gated output from an ungated one. The sync pulses vary in width from one to three cycles, so a detector that counts levels instead of edges drifts from the model. Separate sequences change the duty and the period in the middle of a field, to show that the change waits for the next edge and the count continues. A clear issued mid-run shows that the configuration returns to its reset value even while the inputs request blinking.

// File: rtl/blink_pkg.sv
// Shared types for the blink timing generator.
package blink_pkg;
    // Duty code as held in the shadow register.
    typedef enum logic [1:0] {
        DUTY_OFF = 2'b00,
        DUTY_25  = 2'b01,
        DUTY_50  = 2'b10,
        DUTY_75  = 2'b11
    } duty_e;
endpackage

// File: rtl/blink_edge_det.sv
// Rising-edge detector for vertical sync.
// Assumes vsync is already synchronous to clk. It produces a one-cycle
// tick for each 0-to-1 transition.
module blink_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic field_tick
);
    logic vs_q;

    // Remember the previous vsync level.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync;
    end

    assign field_tick = vsync & ~vs_q;

    // R2: a tick never lasts two cycles
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        field_tick |=> !field_tick);
endmodule

// File: rtl/blink_field_ctr.sv
// Wrapping field counter.
// It advances once per field tick and is never reset by a
// configuration change.
module blink_field_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // Count fields modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (field_tick) cnt <= cnt + 1'b1;
    end

    // R1: clear empties the counter
    p_clear_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));
    // R2: one step per tick
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (field_tick && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
    // R2: wrap from the top value
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (field_tick && cnt == TOP) |=> (cnt == '0));
    // R2: no movement between ticks
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !field_tick |=> $stable(cnt));
endmodule

// File: rtl/blink_cfg_shadow.sv
// Shadow copy of the period and duty settings.
// It captures new values only at a field tick, so a change takes
// effect from the next field.
module blink_cfg_shadow
    import blink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_tick,
    input  logic       half_in,
    input  logic [1:0] duty_in,
    output logic       half_q,
    output duty_e      duty_q
);
    // Load the settings on each field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            duty_q <= DUTY_OFF;
        end else if (field_tick) begin
            half_q <= half_in;
            duty_q <= duty_e'(duty_in);
        end
    end

    // R1: clear zeroes the settings
    p_clear_cfg_r1: assert property (@(posedge clk)
        !rst_n |=> (duty_q == DUTY_OFF && !half_q));
    // R7: settings move only on a tick
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_tick |=> ($stable(duty_q) && $stable(half_q)));
endmodule

// File: rtl/blink_phase_cmp.sv
// Blink phase comparator.
// It selects the counter bits for the active period and compares the
// position with duty * period / 4. Code 00 forces the on phase.
// Assumes CNT_W >= 3.
module blink_phase_cmp
    import blink_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             half_q,
    input  duty_e            duty_q,
    output logic             on_phase
);
    localparam int PW = CNT_W + 1;
    localparam logic [PW-1:0] Q_LONG  = PW'(1 << (CNT_W - 2));
    localparam logic [PW-1:0] Q_SHORT = PW'(1 << (CNT_W - 3));

    logic [PW-1:0] quarter, thr, pos;

    // Build the threshold and the position for the active period.
    always_comb begin
        quarter  = half_q ? Q_SHORT : Q_LONG;
        thr      = quarter * {{(PW-2){1'b0}}, duty_q};
        pos      = half_q ? {2'b00, cnt[CNT_W-2:0]} : {1'b0, cnt};
        on_phase = (duty_q == DUTY_OFF) || (pos < thr);
    end
endmodule

// File: rtl/blink_timing_gen.sv
// Top of the character blink timing generator.
// It joins edge detection, the field counter, the settings shadow and
// the phase comparator. Then it gates the phase with the per-cell
// attribute and the cursor enable, combinationally.
module blink_timing_gen
    import blink_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       half_period,
    input  logic [1:0] duty,
    input  logic       cell_blink,
    input  logic       cursor_blink_en,
    output logic       char_visible,
    output logic       cursor_visible
);
    localparam logic [CNT_W-1:0] Q_LONG = CNT_W'(1 << (CNT_W - 2));

    logic             field_tick;
    logic [CNT_W-1:0] cnt;
    logic             half_q;
    duty_e            duty_q;
    logic             on_phase;

    blink_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .field_tick (field_tick)
    );

    blink_field_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_tick (field_tick),
        .cnt        (cnt)
    );

    blink_cfg_shadow u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_tick (field_tick),
        .half_in    (half_period),
        .duty_in    (duty),
        .half_q     (half_q),
        .duty_q     (duty_q)
    );

    blink_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
        .cnt        (cnt),
        .half_q     (half_q),
        .duty_q     (duty_q),
        .on_phase   (on_phase)
    );

    // Gate the phase by the cell attribute and the cursor enable.
    always_comb begin
        char_visible   = !cell_blink      || on_phase;
        cursor_visible = !cursor_blink_en || on_phase;
    end

    // R1: visible while clear is applied
    p_clear_visible_r1: assert property (@(posedge clk)
        !rst_n |=> (char_visible && cursor_visible));
    // R4: code 00 never hides anything
    p_off_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == DUTY_OFF) |-> (char_visible && cursor_visible));
    // R4: a quarter duty on the long period hides past the first quarter
    p_quarter_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == DUTY_25 && !half_q && cnt >= Q_LONG)
            |-> (char_visible == !cell_blink));
    // R5: plain cells always shown
    p_plain_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_blink |-> char_visible);
    // R6: steady cursor always shown
    p_steady_cursor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cursor_blink_en |-> cursor_visible);
endmodule

// File: tb/blink_timing_gen_test.sv
module blink_timing_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       half_period = 1'b0;
    logic [1:0] duty = 2'b00;
    logic       cell_blink = 1'b0;
    logic       cursor_blink_en = 1'b0;
    logic       char_visible, cursor_visible;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int  m_cnt = 0;
    int  m_duty = 0;
    bit  m_half = 1'b0;

    always #5 clk = ~clk;

    blink_timing_gen uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .vsync           (vsync),
        .half_period     (half_period),
        .duty            (duty),
        .cell_blink      (cell_blink),
        .cursor_blink_en (cursor_blink_en),
        .char_visible    (char_visible),
        .cursor_visible  (cursor_visible)
    );

    function automatic bit model_on();
        int p;
        int pos;
        p   = m_half ? 32 : 64;
        pos = m_cnt % p;
        return (m_duty == 0) || (pos < (m_duty * p) / 4);
    endfunction

    // One vsync pulse of w cycles; model updates at the rising edge (R2, R7)
    task automatic pulse(input int w);
        @(negedge clk);
        vsync = 1'b1;
        repeat (w) @(negedge clk);
        vsync = 1'b0;
        m_cnt  = (m_cnt + 1) % 64;
        m_duty = duty;
        m_half = half_period;
    endtask

    task automatic cmp(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b cnt=%0d duty=%0d half=%0b",
                     req, act, exp, m_cnt, m_duty, m_half);
        end
    endtask

    // All attribute/enable combinations against the model (R3 R4 R5 R6)
    task automatic check_all(input string req);
        bit on;
        on = model_on();
        for (int k = 0; k < 4; k++) begin
            cell_blink      = k[0];
            cursor_blink_en = k[1];
            #1;
            cmp({req, "/R5 char"},   char_visible,   !k[0] || on);
            cmp({req, "/R6 cursor"}, cursor_visible, !k[1] || on);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with blink-requesting inputs
        duty = 2'b11;
        half_period = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release, no vsync yet");

        // R3 R4: full sweep of period and duty with variable pulse widths (R2)
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 4; d++) begin
                half_period = p[0];
                duty = d[1:0];
                pulse(1);
                check_all("R4 load");
                for (int i = 0; i < 64; i++) begin
                    pulse(1 + (i % 3));
                    check_all(p == 0 ? "R3 long R4 sweep" : "R3 short R4 sweep");
                end
            end
        end

        // R7: a duty change waits for the next vsync
        half_period = 1'b0;
        duty = 2'b01;
        pulse(1);
        while (m_cnt != 21) pulse(2);
        check_all("R7 base");
        duty = 2'b11;
        repeat (3) @(negedge clk);
        check_all("R7 duty held");
        pulse(1);
        check_all("R7 duty applied, count kept");
        // R7: a period change waits too, counter keeps counting
        half_period = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R7 period held");
        pulse(1);
        check_all("R7 period applied");
        pulse(3);
        check_all("R7 R3 after period change");

        // R1: mid-run clear restores defaults while inputs ask for blinking
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        m_cnt = 0; m_duty = 0; m_half = 1'b0;
        check_all("R1 mid-run clear");
        rst_n = 1'b1;
        duty = 2'b01;
        half_period = 1'b0;
        pulse(1);
        check_all("R1 R2 count restarts");
        for (int i = 0; i < 20; i++) pulse(1);
        check_all("R2 R4 count after clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule